// File: doc/BRIEF.md
# Serial Port Modem Control with Diagnostic Loopback

This block keeps the modem control byte of one serial port. Its enabled bits drive the two hardware handshake outputs (terminal ready, request to send) and two auxiliary outputs. The second auxiliary bit also gates the port's interrupt request onto the shared interrupt line. The byte is written and read back through a simple byte port.

A fifth bit selects a self-test loopback. In that mode the transmit stream is returned to the receiver inside the block, and the external transmit pin idles at mark. The four control bits are fed back as the four modem status lines. The external handshake outputs go inactive and both auxiliary pins are forced high. No interrupt reaches the bus while the test runs.

Every output is a register. A status or data input shows at the matching output one clock after it is sampled. A new control byte takes effect on the pins one clock after it lands in the register.

Top module: `modem_ctl_loop`

## Requirements
- R1: After a synchronous reset the control byte reads 0x00. The handshake and auxiliary outputs, the four status outputs and the interrupt output are all 0. The transmit pin is 1 (mark), and the receive output follows the receive pin.
- R2: A write (wr_en=1 at a clock edge) stores the byte. From the next cycle, rd_data returns it with bits 7..5 forced to 0. The bit positions are: bit0 terminal-ready, bit1 request-to-send, bit2 aux1, bit3 aux2, bit4 loopback.
- R3: With bit4=0, the outputs dtr_o, rts_o, out1_o and out2_o equal bits 0..3 of the register one cycle after the register changes.
- R4: With bit4=0, cts_o, dsr_o, ri_o, dcd_o and rx_o follow cts_i, dsr_i, ri_i, dcd_i and rx_i, and tx_o follows tx_i, each one cycle after sampling.
- R5: With bit4=0, irq_o equals irq_i AND bit3, one cycle later. Bit2 has no effect on irq_o.
- R6: With bit4=1, tx_o is 1 and rx_o equals tx_i from one cycle earlier. rx_i is ignored.
- R7: With bit4=1, the status outputs are taken from the register: cts_o from bit1, dsr_o from bit0, ri_o from bit2 and dcd_o from bit3. The external status inputs are ignored.
- R8: With bit4=1, dtr_o and rts_o are 0, and out1_o and out2_o are both 1.
- R9: With bit4=1, irq_o stays 0 whatever irq_i and bit3 are.
- R10: A cycle with wr_en=0 leaves the register, and the readback, unchanged whatever wr_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Control byte readback |
| dtr_o | output | 1 | Terminal-ready pin |
| rts_o | output | 1 | Request-to-send pin |
| out1_o | output | 1 | Auxiliary output 1 pin |
| out2_o | output | 1 | Auxiliary output 2 pin |
| cts_i | input | 1 | Clear-to-send pin |
| dsr_i | input | 1 | Data-set-ready pin |
| ri_i | input | 1 | Ring indicator pin |
| dcd_i | input | 1 | Carrier detect pin |
| cts_o | output | 1 | Clear-to-send seen by the port |
| dsr_o | output | 1 | Data-set-ready seen by the port |
| ri_o | output | 1 | Ring indicator seen by the port |
| dcd_o | output | 1 | Carrier detect seen by the port |
| tx_i | input | 1 | Serial data from the transmitter |
| tx_o | output | 1 | Transmit pin |
| rx_i | input | 1 | Receive pin |
| rx_o | output | 1 | Serial data to the receiver |
| irq_i | input | 1 | Raw interrupt request from the port |
| irq_o | output | 1 | Gated interrupt to the bus |

## Verification
A control bit stored in the wrong place shows at once in the readback, the cycle after the write. It reaches the pins one cycle after that, as a handshake or auxiliary output that disagrees with the byte. A loopback flag that is wrong internally does more damage. Outside pins would stay live during self-test, and an interrupt could leak onto the shared line within one cycle of irq_i rising. The table walks normal and loopback bytes with inputs chosen to disagree with the looped sources. Any crossed route therefore appears on the first sample.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic loop;
    logic aux2;
    logic aux1;
    logic req;
    logic term;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] KEEP_MASK = BYTE_W'((1 << CTRL_W) - 1);
  localparam int N_STAT = 4;
endpackage

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_ctl_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) byte_q <= '0;
    else if (wr_en) byte_q <= wr_data & DATA_W'(KEEP_MASK);
  end

  assign ctrl    = ctrl_t'(byte_q[CTRL_W-1:0]);
  assign rd_data = byte_q;

  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & DATA_W'(KEEP_MASK)));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/modem_ctl_route.sv
module modem_ctl_route
  import modem_ctl_pkg::*;
#(
  parameter logic MARK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [N_STAT-1:0] stat_ext_i,
  output logic [N_STAT-1:0] stat_o,
  output logic [N_STAT-1:0] pin_o,
  input  logic              tx_i,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              rx_o
);
  // stat/pin order: [0]=cts/dtr [1]=dsr/rts [2]=ri/aux1 [3]=dcd/aux2
  logic [N_STAT-1:0] loop_src;
  logic [N_STAT-1:0] pin_norm;
  logic [N_STAT-1:0] pin_loop;

  assign loop_src = {ctrl.aux2, ctrl.aux1, ctrl.term, ctrl.req};
  assign pin_norm = {ctrl.aux2, ctrl.aux1, ctrl.req, ctrl.term};
  assign pin_loop = 4'b1100;

  for (genvar g = 0; g < N_STAT; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        stat_o[g] <= 1'b0;
        pin_o[g]  <= 1'b0;
      end else begin
        stat_o[g] <= ctrl.loop ? loop_src[g] : stat_ext_i[g];
        pin_o[g]  <= ctrl.loop ? pin_loop[g] : pin_norm[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_o <= MARK;
      rx_o <= MARK;
    end else begin
      tx_o <= ctrl.loop ? MARK : tx_i;
      rx_o <= ctrl.loop ? tx_i : rx_i;
    end
  end

  p_tx_mark_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.loop |=> tx_o == MARK);
  p_rx_loop_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.loop |=> rx_o == $past(tx_i));
  p_aux_forced_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl.loop |=> (pin_o == 4'b1100));
  p_cts_from_req_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.loop |=> stat_o[0] == $past(ctrl.req));
  p_pins_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loop |=> pin_o[0] == $past(ctrl.term) && pin_o[3] == $past(ctrl.aux2));
endmodule

// File: rtl/modem_ctl_irq.sv
module modem_ctl_irq
  import modem_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  irq_i,
  output logic  irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irq_i & ctrl.aux2 & ~ctrl.loop;
  end

  p_loop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.loop |=> !irq_o);
  p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.aux2 |=> !irq_o);
endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop
  import modem_ctl_pkg::*;
#(
  parameter int   DATA_W = BYTE_W,
  parameter logic MARK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  output logic              cts_o,
  output logic              dsr_o,
  output logic              ri_o,
  output logic              dcd_o,
  input  logic              tx_i,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              rx_o,
  input  logic              irq_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [N_STAT-1:0] stat_q;
  logic [N_STAT-1:0] pin_q;

  modem_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctrl), .rd_data(rd_data)
  );

  modem_ctl_route #(.MARK(MARK)) u_route (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .stat_ext_i({dcd_i, ri_i, dsr_i, cts_i}),
    .stat_o(stat_q), .pin_o(pin_q),
    .tx_i(tx_i), .tx_o(tx_o), .rx_i(rx_i), .rx_o(rx_o)
  );

  modem_ctl_irq u_irq (
    .clk(clk), .rst(rst), .ctrl(ctrl), .irq_i(irq_i), .irq_o(irq_o)
  );

  assign {dcd_o, ri_o, dsr_o, cts_o} = stat_q;
  assign {out2_o, out1_o, rts_o, dtr_o} = pin_q;

  p_ext_status_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loop |=> cts_o == $past(cts_i) && dcd_o == $past(dcd_i));
  p_no_leak_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(!ctrl.loop && ctrl.aux2 && irq_i));
endmodule

// File: tb/modem_ctl_loop_tb_top.sv
`timescale 1ns/1ps
module modem_ctl_loop_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic dtr_o, rts_o, out1_o, out2_o;
  logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic cts_o, dsr_o, ri_o, dcd_o;
  logic tx_i = 1, tx_o, rx_i = 1, rx_o, irq_i = 0, irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  modem_ctl_loop dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
    .cts_o(cts_o), .dsr_o(dsr_o), .ri_o(ri_o), .dcd_o(dcd_o),
    .tx_i(tx_i), .tx_o(tx_o), .rx_i(rx_i), .rx_o(rx_o),
    .irq_i(irq_i), .irq_o(irq_o)
  );

  // inputs {cts,dsr,ri,dcd,tx,rx,irq}; outputs {dtr,rts,o1,o2,cts,dsr,ri,dcd,tx,rx,irq}
  typedef struct packed {
    logic [7:0]  wbyte;
    logic [6:0]  ins;
    logic [7:0]  rd;
    logic [10:0] outs;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{8'h03, 7'b1010011, 8'h03, 11'b1100_1010_010},  // R3 R4 normal, irq gated off
    '{8'h0B, 7'b0101101, 8'h0B, 11'b1101_0101_101},  // R5 irq passes
    '{8'h0C, 7'b1100110, 8'h0C, 11'b0011_1100_110},  // R3 aux bits
    '{8'h04, 7'b0000001, 8'h04, 11'b0010_0000_000},  // R5 aux1 no effect
    '{8'h13, 7'b0011011, 8'h13, 11'b0011_1100_100},  // R6 R7 R8 loop
    '{8'h1C, 7'b1100101, 8'h1C, 11'b0011_0011_110},  // R7 R9 loop
    '{8'hFF, 7'b1111001, 8'h1F, 11'b0011_1111_100},  // R2 upper bits dropped, loop
    '{8'hE8, 7'b0000111, 8'h08, 11'b0001_0000_111}   // R2 R5 normal again
  };

  function automatic logic [10:0] outs_now();
    return {dtr_o, rts_o, out1_o, out2_o, cts_o, dsr_o, ri_o, dcd_o, tx_o, rx_o, irq_o};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ins(input logic [6:0] v);
    {cts_i, dsr_i, ri_i, dcd_i, tx_i, rx_i, irq_i} = v;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h5A;
  endtask

  initial begin : watchdog
    #200000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rd", {8'h0, rd_data}, 16'h0000);
    check("R1 pins", {5'h0, outs_now()}, {5'h0, 11'b0000_0000_110});

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_ins(VT[i].ins);
      wr_en = 1'b1; wr_data = VT[i].wbyte;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 readback", {8'h0, rd_data}, {8'h0, VT[i].rd});
      @(posedge clk);
      @(negedge clk);
      check("R3-table outputs", {5'h0, outs_now()}, {5'h0, VT[i].outs});
    end

    // R10: wr_en low with other data leaves byte and pins alone
    @(negedge clk);
    wr_data = 8'h1F;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 rd", {8'h0, rd_data}, 16'h0008);
    check("R10 pins", {5'h0, outs_now()}, {5'h0, 11'b0001_0000_111});

    // R4: one-cycle latency of status input in normal mode
    @(negedge clk);
    cts_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R4 cts latency", {15'h0, cts_o}, 16'h0001);

    // R5: irq drop propagates in one cycle
    irq_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R5 irq drop", {15'h0, irq_o}, 16'h0000);

    // R6 R9: enter loop with aux2 set, toggle tx and irq
    write_byte(8'h18);
    irq_i = 1'b1; tx_i = 1'b0; rx_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 irq quiet", {15'h0, irq_o}, 16'h0000);
    check("R6 rx from tx", {14'h0, tx_o, rx_o}, 16'h0002);
    tx_i = 1'b1; rx_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 rx follows tx", {14'h0, tx_o, rx_o}, 16'h0003);

    // R7: external status ignored in loop
    {cts_i, dsr_i, ri_i, dcd_i} = 4'b1111;
    @(posedge clk);
    @(negedge clk);
    check("R7 status looped", {12'h0, cts_o, dsr_o, ri_o, dcd_o}, 16'h0001);

    // R5: leave loop, irq reappears
    write_byte(8'h08);
    @(posedge clk);
    @(negedge clk);
    check("R5 irq after loop", {15'h0, irq_o}, 16'h0001);
    check("R8 pins after loop", {12'h0, dtr_o, rts_o, out1_o, out2_o}, 16'h0001);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset again", {8'h0, rd_data}, 16'h0000);
    check("R1 irq after reset", {15'h0, irq_o}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule